// File: doc/BRIEF.md
# I2C Target Read Engine

This block is an I2C target that serves reads from a 256-byte array held inside the block. Both bus lines are oversampled by the system clock through synchronizers. START, repeated START and STOP are decoded from those samples, and a 7-bit target address is compared against the first byte of each transfer. The engine never drives SDA high. It only asserts a pull-low enable, and the pad or the bench forms the wired-AND with the pull-up.

A persistent byte pointer always holds one past the last location served. A plain read (address byte with R/W set) returns data from the pointer. A dummy write, made of the address byte with R/W clear followed by one byte-address byte, loads the pointer and then a repeated START reads from it. Each master ACK after a data byte streams the next location. The pointer wraps from the top of the array to zero. A write-side preload port fills the array so that there is content to read.

Top module: `i2c_rd_engine`

## Requirements
- R1: After reset the pull-low enable is 0 and the pointer is 0, so the first plain read returns the byte at location 0.
- R2: START (SDA falling while SCL is high) and STOP (SDA rising while SCL is high) both release SDA. After a STOP the engine stays idle until the next START.
- R3: An address byte whose upper seven bits equal the target address is acknowledged with SDA low during the ninth clock. On any other address the engine gives no ACK and keeps SDA released for the rest of the transfer.
- R4: A plain read returns the byte at the pointer, most significant bit first.
- R5: The pointer advances by one for each byte served, so the next plain read returns the byte that follows the last one served.
- R6: Past location 255 the pointer wraps to 0, and the data stays valid across the wrap.
- R7: Each master ACK after a data byte makes the engine send the next location within the same transfer.
- R8: After a master NACK the engine releases SDA and drives nothing until START or STOP.
- R9: A write-direction address byte followed by a byte-address byte gets an ACK on both bytes and loads the pointer with the byte address. A repeated START with a read then returns data from that address.
- R10: Any byte that follows the byte-address byte in a write transfer gets no ACK and leaves the array unchanged.
- R11: The pull-low enable changes only while SCL is low.
- R12: When ld_we_i is high at a clock edge, ld_data_i is stored at ld_addr_i and is returned by later reads of that location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| ld_we_i | input | 1 | Preload write enable |
| ld_addr_i | input | 8 | Preload location |
| ld_data_i | input | 8 | Preload byte |

## Verification
The hardest case to reach from the pins is a sequential stream that crosses the top of the array. It only happens when a dummy write parks the pointer a few bytes below 255 and the master keeps sending ACKs through the wrap. The bench reaches it with a directed random read at 254 that runs for four bytes, and the random phase adds more such runs by choosing start addresses and lengths. A second hard case is a write transfer that carries a data byte after the byte address. The bench sends one, checks that it gets no ACK, and then reads the location back.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_BADDR,
    ST_BADDR_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_SKIP
  } st_e;
endpackage

// File: rtl/i2c_rd_sync.sv
module i2c_rd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign start_o = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
  assign rise_o  = scl_o & ~scl_q;
  assign fall_o  = ~scl_o & scl_q;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (ld_we_i) mem[ld_addr_i] <= ld_data_i;
    rd_data_o <= mem[rd_addr_i];
  end
endmodule

// File: rtl/i2c_rd_ctrl.sv
module i2c_rd_ctrl
  import i2c_rd_pkg::*;
#(
  parameter int          AW  = 8,
  parameter int          DW  = 8,
  parameter logic [6:0]  TGT = 7'h50
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          sda_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] ptr_o
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  st_e           state;
  logic [CW-1:0] cnt;
  logic [DW-1:0] sh;
  logic          rw, mack;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      sda_oe_o <= 1'b0;
      ptr_o    <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
    end else if (start_i) begin
      state    <= ST_ADDR;
      cnt      <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_i) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_BADDR: begin
          if (rise_i && cnt != CNT_FULL) begin
            sh  <= {sh[DW-2:0], sda_i};
            cnt <= cnt + 1'b1;
          end else if (fall_i && cnt == CNT_FULL) begin
            cnt <= '0;
            if (state == ST_ADDR) begin
              if (sh[DW-1:1] == TGT) begin
                sda_oe_o <= 1'b1;
                rw       <= sh[0];
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_SKIP;
              end
            end else begin
              ptr_o    <= sh[AW-1:0];
              sda_oe_o <= 1'b1;
              state    <= ST_BADDR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (fall_i) begin
            if (rw) begin
              sh       <= rd_data_i;
              ptr_o    <= ptr_o + 1'b1;
              sda_oe_o <= ~rd_data_i[DW-1];
              cnt      <= '0;
              state    <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_BADDR;
            end
          end
        end
        ST_BADDR_ACK: begin
          if (fall_i) begin
            sda_oe_o <= 1'b0;
            state    <= ST_SKIP;
          end
        end
        ST_TX: begin
          if (fall_i) begin
            if (cnt == CNT_LAST) begin
              sda_oe_o <= 1'b0;
              state    <= ST_TX_ACK;
            end else begin
              sh       <= {sh[DW-2:0], 1'b0};
              cnt      <= cnt + 1'b1;
              sda_oe_o <= ~sh[DW-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (rise_i) mack <= ~sda_i;
          if (fall_i) begin
            if (mack) begin
              sh       <= rd_data_i;
              ptr_o    <= ptr_o + 1'b1;
              sda_oe_o <= ~rd_data_i[DW-1];
              cnt      <= '0;
              state    <= ST_TX;
            end else begin
              state <= ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine #(
  parameter int         AW     = 8,
  parameter int         DW     = 8,
  parameter logic [6:0] TGT    = 7'h50,
  parameter int         STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          ld_we_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [DW-1:0] ld_data_i
);
  logic scl_s, sda_s, start_det, stop_det, scl_rise, scl_fall;
  logic [AW-1:0] ptr;
  logic [DW-1:0] rd_data;

  i2c_rd_sync #(.STAGES(STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .start_o(start_det), .stop_o(stop_det),
    .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_rd_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i, .ld_we_i, .ld_addr_i, .ld_data_i,
    .rd_addr_i(ptr), .rd_data_o(rd_data)
  );

  i2c_rd_ctrl #(.AW(AW), .DW(DW), .TGT(TGT)) u_ctrl (
    .clk_i, .rst_ni, .start_i(start_det), .stop_i(stop_det),
    .rise_i(scl_rise), .fall_i(scl_fall), .sda_i(sda_s),
    .rd_data_i(rd_data), .sda_oe_o, .ptr_o(ptr)
  );
endmodule

// File: rtl/i2c_rd_engine_chk.sv
module i2c_rd_engine_chk #(
  parameter int AW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          scl_s_i,
  input logic          start_i,
  input logic          stop_i,
  input logic          sda_oe_i,
  input logic [AW-1:0] ptr_i
);
  p_reset_release_r1: assert property (@(posedge clk_i) !rst_ni |-> !sda_oe_i);

  p_stop_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> !sda_oe_i);

  p_start_release_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !sda_oe_i);

  p_oe_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !scl_s_i);

  // pointer moves only on SCL falling edges (R5, R9)
  p_ptr_scl_low_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr_i != $past(ptr_i)) |-> !scl_s_i);
endmodule

bind i2c_rd_engine i2c_rd_engine_chk #(.AW(AW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .start_i(start_det),
  .stop_i(stop_det), .sda_oe_i(sda_oe_o), .ptr_i(ptr)
);

// File: tb/i2c_rd_engine_test.sv
module i2c_rd_engine_test;
  localparam int CLK_P = 10;
  localparam int Q = 10;
  localparam logic [6:0] TGT = 7'h50;

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1;
  logic sda_oe, sda_line;
  logic ld_we = 0;
  logic [7:0] ld_addr = 0, ld_data = 0;
  logic [7:0] exp_mem [256];
  logic [7:0] exp_ptr = 0;
  int errors = 0, checks = 0, viol = 0;
  bit finished = 0;
  logic oe_prev = 0;

  assign sda_line = sda_m & ~sda_oe;
  always #(CLK_P/2) clk = ~clk;

  i2c_rd_engine #(.TGT(TGT)) uut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .ld_we_i(ld_we), .ld_addr_i(ld_addr), .ld_data_i(ld_data)
  );

  // R11 monitor: pull enable must not move while SCL is high
  always @(posedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic preload(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_we = 1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_we = 0;
    exp_mem[a] = d;
  endtask

  task automatic bus_start();
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic bus_stop();
    scl_m = 0; tick(Q); sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    end
    sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = !sda_line; tick(Q); scl_m = 0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 0;
    end
    tick(Q);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
    sda_m = 1;
  endtask

  // optional pointer load by dummy write, then n-byte read
  task automatic do_read(input bit set_addr, input logic [7:0] addr, input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    if (set_addr) begin
      send_byte({TGT, 1'b0}, ack);
      check(ack, "R3 write address ack", ack, 1);
      send_byte(addr, ack);
      check(ack, "R9 byte address ack", ack, 1);
      exp_ptr = addr;
      bus_start();
    end
    send_byte({TGT, 1'b1}, ack);
    check(ack, "R3 read address ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(b == exp_mem[exp_ptr], req, b, exp_mem[exp_ptr]);
      exp_ptr = exp_ptr + 1;
    end
    tick(4*Q);
    check(sda_oe == 0, "R8 released after NACK", sda_oe, 0);
    bus_stop();
    tick(5);
    check(sda_oe == 0, "R2 released after STOP", sda_oe, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'd4242));
    tick(3);
    check(sda_oe == 0, "R1 reset release", sda_oe, 0);
    rst_n = 1;
    tick(3);
    for (int a = 0; a < 256; a++) preload(8'(a), 8'($urandom));

    do_read(0, 0, 1, "R1 R4 first plain read at 0");
    do_read(0, 0, 2, "R5 R7 pointer advances");
    do_read(1, 8'h10, 5, "R9 R7 random sequential");
    do_read(1, 8'hFE, 4, "R6 wrap past top");

    // R3 mismatch: no ack, bus stays released
    bus_start();
    send_byte({TGT ^ 7'h01, 1'b1}, ack);
    check(!ack, "R3 no ack on other address", ack, 0);
    recv_byte(1, b);
    check(b == 8'hFF, "R3 ignored transfer released", b, 8'hFF);
    bus_stop();
    do_read(0, 0, 1, "R3 pointer kept after mismatch");

    // R10 data byte after byte address
    bus_start();
    send_byte({TGT, 1'b0}, ack);
    send_byte(8'h33, ack);
    check(ack, "R9 byte address ack", ack, 1);
    send_byte(~exp_mem[8'h33], ack);
    check(!ack, "R10 data byte not acked", ack, 0);
    bus_stop();
    exp_ptr = 8'h33;
    do_read(0, 0, 1, "R10 memory unchanged");

    preload(8'h07, 8'hA5);
    do_read(1, 8'h07, 1, "R12 preload visible");

    for (int k = 0; k < 20; k++) begin
      bit sa = 1'($urandom);
      do_read(sa, 8'($urandom), 1 + int'($urandom % 4), "R4 R5 R7 random run");
    end

    check(viol == 0, "R11 pull enable change with SCL high", viol, 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule